// File: doc/BRIEF.md
# Reset Preboot Window and Debug Lock

This block sequences the first moments after every reset. It counts retired instructions until a fixed preboot limit is reached. The limit is 30 or 60, chosen by a parameter. For the whole of that window the debug port is held off. Once the window closes, the port turns on by itself, unless boot code asked for it to stay off.

Boot code has two single-cycle write strobes: one requests that debug stay off, the other raises a secure status bit. Both take effect only while the window is open. A strobe that arrives after the window changes nothing, but it raises a sticky violation flag that reset alone clears.

The debug-disable bit has two build-time flavours. In volatile mode a reset clears it. In fuse mode it can only be set, and the reset input never clears it. Only the power-on initial value starts it at zero.

Top module: `preboot_guard`

## Requirements
- R1: After reset release, `preboot_o` is high until `LONG_WINDOW` selects the limit (0 gives 30, 1 gives 60) and that many cycles with `retire_i` high have been counted. It then goes low.
- R2: `dbg_en_o` is low whenever `preboot_o` is high, including during reset.
- R3: Once the window has closed, `dbg_en_o` is high unless a disable request was accepted in the window.
- R4: A `dbg_off_wr_i` pulse in a cycle with `preboot_o` high makes `dbg_en_o` stay low after the window. This includes the cycle that carries the last counted retire.
- R5: `dbg_off_wr_i` or `secure_wr_i` pulses in a cycle with `preboot_o` low leave `dbg_en_o` and `secure_o` unchanged.
- R6: Any write pulse in a cycle with `preboot_o` low sets `viol_o` from the next cycle on. It stays high until reset, and reset clears it.
- R7: A `secure_wr_i` pulse in a cycle with `preboot_o` high sets `secure_o` from the next cycle on. It holds until reset, and reset clears it.
- R8: With `FUSE_MODE` = 0, reset clears the disable request, so the next window ends with `dbg_en_o` high.
- R9: With `FUSE_MODE` = 1, an accepted disable request survives every later reset, and `dbg_en_o` stays low after each later window.
- R10: Retire pulses after the window closes do not reopen it. `preboot_o` stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One pulse per retired instruction |
| dbg_off_wr_i | input | 1 | Write strobe requesting the debug port stay off |
| secure_wr_i | input | 1 | Write strobe setting the secure status bit |
| dbg_en_o | output | 1 | Debug port enable |
| preboot_o | output | 1 | Preboot window open |
| secure_o | output | 1 | Secure status bit |
| viol_o | output | 1 | Sticky late-write flag |

## Verification
Two instances run side by side from the same stimulus: a 30-retire volatile build and a 60-retire fuse build. Write pulses that land inside one window and past the other therefore separate acceptance from rejection within one run.

Retires arrive with idle gaps. This shows that the counter follows retires rather than cycles. A write placed on the very retire that closes the window probes the boundary. Extra retires after the window show that it does not reopen.

Repeated resets separate the volatile build, which forgets the disable request, from the fuse build, which keeps it.

// File: rtl/pb_pkg.sv
package pb_pkg;
  // Window length in retired instructions for each build choice.
  function automatic int unsigned pb_window_len(bit long_win);
    return long_win ? 60 : 30;
  endfunction

  // Next count: advances only while the window is open.
  function automatic int unsigned pb_cnt_next(int unsigned cnt, bit retire, int unsigned lim);
    return (retire && cnt < lim) ? cnt + 1 : cnt;
  endfunction
endpackage

// File: rtl/pb_window_ctr.sv
module pb_window_ctr #(
  parameter int unsigned LEN = 30,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  output logic open_o
);
  import pb_pkg::*;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(pb_cnt_next(int'(cnt_q), retire_i, LEN));
  end

  assign open_o = (cnt_q < CW'(LEN));
endmodule

// File: rtl/pb_lock_bits.sv
module pb_lock_bits #(
  parameter bit FUSE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic dis_wr_i,
  input  logic sec_wr_i,
  output logic dis_o,
  output logic sec_o,
  output logic viol_o
);
  logic accept_dis_w, accept_sec_w, late_w;
  assign accept_dis_w = open_i & dis_wr_i;
  assign accept_sec_w = open_i & sec_wr_i;
  assign late_w       = ~open_i & (dis_wr_i | sec_wr_i);

  generate
    if (FUSE_MODE) begin : g_fuse
      // Set-only bit; reset input has no effect, power-on value only.
      logic fuse_q = 1'b0;
      always_ff @(posedge clk) begin
        if (accept_dis_w) fuse_q <= 1'b1;
      end
      assign dis_o = fuse_q;
    end else begin : g_volatile
      logic dis_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            dis_q <= 1'b0;
        else if (accept_dis_w) dis_q <= 1'b1;
      end
      assign dis_o = dis_q;
    end
  endgenerate

  logic sec_q, viol_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (accept_sec_w) sec_q  <= 1'b1;
      if (late_w)       viol_q <= 1'b1;
    end
  end

  assign sec_o  = sec_q;
  assign viol_o = viol_q;
endmodule

// File: rtl/preboot_guard.sv
module preboot_guard #(
  parameter bit LONG_WINDOW = 1'b0,
  parameter bit FUSE_MODE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  input  logic dbg_off_wr_i,
  input  logic secure_wr_i,
  output logic dbg_en_o,
  output logic preboot_o,
  output logic secure_o,
  output logic viol_o
);
  import pb_pkg::*;
  localparam int unsigned WIN_LEN = pb_window_len(LONG_WINDOW);

  logic open_w, dis_w;

  pb_window_ctr #(.LEN(WIN_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .open_o(open_w)
  );

  pb_lock_bits #(.FUSE_MODE(FUSE_MODE)) u_bits (
    .clk(clk), .rst_n(rst_n), .open_i(open_w),
    .dis_wr_i(dbg_off_wr_i), .sec_wr_i(secure_wr_i),
    .dis_o(dis_w), .sec_o(secure_o), .viol_o(viol_o)
  );

  assign preboot_o = open_w;
  assign dbg_en_o  = ~open_w & ~dis_w;
endmodule

// File: rtl/pb_guard_chk.sv
module pb_guard_chk #(
  parameter bit FUSE_MODE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic dbg_off_wr_i,
  input logic secure_wr_i,
  input logic dbg_en_o,
  input logic preboot_o,
  input logic secure_o,
  input logic viol_o
);
  AST_DBG_OFF_IN_WINDOW: assert property (@(posedge clk) preboot_o |-> !dbg_en_o); // R2
  AST_WINDOW_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !preboot_o |=> !preboot_o); // R10
  AST_SECURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    secure_o |=> secure_o); // R7
  AST_VIOL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o); // R6
  AST_LATE_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (!preboot_o && (dbg_off_wr_i || secure_wr_i)) |=> viol_o); // R6
  AST_LATE_SECURE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!preboot_o && !secure_o) |=> !secure_o); // R5
  AST_LATE_DBG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!preboot_o && dbg_en_o) |=> dbg_en_o); // R5
  AST_FUSE_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (FUSE_MODE && !preboot_o && !dbg_en_o) |=> !dbg_en_o); // R9
endmodule

bind preboot_guard pb_guard_chk #(.FUSE_MODE(FUSE_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_off_wr_i(dbg_off_wr_i), .secure_wr_i(secure_wr_i),
  .dbg_en_o(dbg_en_o), .preboot_o(preboot_o), .secure_o(secure_o), .viol_o(viol_o)
);

// File: tb/preboot_guard_tb.sv
module preboot_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire = 1'b0, dwr = 1'b0, swr = 1'b0;
  logic [1:0] en, pre, sec, vio;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  preboot_guard #(.LONG_WINDOW(1'b0), .FUSE_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .dbg_off_wr_i(dwr), .secure_wr_i(swr),
    .dbg_en_o(en[0]), .preboot_o(pre[0]), .secure_o(sec[0]), .viol_o(vio[0]));
  preboot_guard #(.LONG_WINDOW(1'b1), .FUSE_MODE(1'b1)) u_dut_fuse (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .dbg_off_wr_i(dwr), .secure_wr_i(swr),
    .dbg_en_o(en[1]), .preboot_o(pre[1]), .secure_o(sec[1]), .viol_o(vio[1]));

  // Reference model: index 0 volatile/30, index 1 fuse/60
  int m_cnt[2] = '{0, 0};
  bit m_dis[2] = '{0, 0};
  bit m_sec[2] = '{0, 0};
  bit m_vio[2] = '{0, 0};
  int lim[2]   = '{30, 60};
  bit fz[2]    = '{0, 1};

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_cnt[i] = 0; m_sec[i] = 0; m_vio[i] = 0;
        if (!fz[i]) m_dis[i] = 0;
      end else if (m_cnt[i] < lim[i]) begin
        if (dwr) m_dis[i] = 1;
        if (swr) m_sec[i] = 1;
        if (retire) m_cnt[i]++;
      end else if (dwr || swr) m_vio[i] = 1;
    end
  end

  task automatic chk(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      bit mp;
      mp = m_cnt[i] < lim[i];
      chk(pre[i], mp, "R1 preboot");
      chk(en[i], !mp && !m_dis[i], "R3 dbg_en");
      chk(sec[i], m_sec[i], "R7 secure");
      chk(vio[i], m_vio[i], "R6 viol");
    end
  endtask

  task automatic cyc(bit r, bit d, bit s);
    retire = r; dwr = d; swr = s;
    @(negedge clk);
    compare();
    retire = 0; dwr = 0; swr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) cyc(0, 0, 0);
    rst_n = 1;
  endtask

  task automatic retires(int n);
    for (int k = 0; k < n; k++) begin cyc(1, 0, 0); cyc(0, 0, 0); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(pre[0], 1, "R1 reset preboot"); chk(en[0], 0, "R2 reset dbg off");
    chk(sec[0], 0, "R7 reset secure");  chk(vio[0], 0, "R6 reset viol");
    retires(30);
    chk(pre[0], 0, "R1 window closed at 30"); chk(en[0], 1, "R3 default enable");
    chk(pre[1], 1, "R1 long window open");    chk(en[1], 0, "R2 off in window");
    retires(10);
    chk(pre[0], 0, "R10 no reopen");
    cyc(0, 1, 1);
    cyc(0, 0, 0);
    chk(en[0], 1, "R5 late disable ignored"); chk(sec[0], 0, "R5 late secure ignored");
    chk(vio[0], 1, "R6 late write flagged");  chk(vio[1], 0, "R6 in-window no flag");
    chk(sec[1], 1, "R7 secure set in window");
    retires(20);
    chk(pre[1], 0, "R1 long window closed");  chk(en[1], 0, "R4 disable honoured");
    do_reset();
    chk(vio[0], 0, "R6 reset clears viol");
    repeat (29) cyc(1, 0, 0);
    cyc(1, 1, 1);
    cyc(0, 0, 0);
    chk(pre[0], 0, "R4 boundary window closed"); chk(en[0], 0, "R4 boundary write accepted");
    chk(sec[0], 1, "R7 boundary secure");        chk(vio[0], 0, "R6 boundary no flag");
    do_reset();
    retires(60);
    chk(en[0], 1, "R8 volatile cleared by reset");
    chk(pre[1], 0, "R1 long window closed again");
    chk(en[1], 0, "R9 fuse survives reset");
    do_reset();
    retires(60);
    chk(en[1], 0, "R9 fuse survives second reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule